// File: doc/BRIEF.md
# ULPI PHY Low-Power Mode Controller

This block sits on the transceiver side of a ULPI link and moves the bus between normal synchronous operation and the low-power (suspend) state. The link asks for suspend by writing the function control register with its suspend-enable bit cleared. The block then takes ownership of the bus by raising DIR. After one turnaround cycle it presents a reduced status byte on the data lines. That byte carries the two raw line-state bits and a sticky interrupt flag.

While suspended, each unmasked interrupt source is compared with the value it had at entry. Any difference sets the flag, and the flag holds for the rest of the session. A STP request is honoured only after a minimum residency, set by a parameter. On exit the block releases the bus for one cycle and sets the suspend-enable bit back to 1. If an unmasked source changed during suspend and still differs from its entry value, the block then takes the bus again and issues a single RX CMD byte.

Top module: `ulpi_lpm_ctrl`

## Requirements
- R1: While reset is held and in the cycle after its release, dir is 0, nxt is 0, dout is 00h and susp_en_o reads 1 (synchronous mode).
- R2: A cycle with fc_wr high and fc_wdata[SUSP_BIT] = 0, in synchronous mode, makes dir 1 and susp_en_o 0 from the next cycle on. A write with fc_wdata[SUSP_BIT] = 1 leaves dir at 0 and susp_en_o at 1.
- R3: In the first cycle that dir is high, dout carries no status and is driven to 00h.
- R4: In each later suspended cycle, dout[1:0] equals linestate in the same cycle, and dout[2] and dout[7:4] are 0.
- R5: dout[3] goes to 1 one cycle after any source with irq_mask bit = 1 differs from its value at entry. It then stays 1 until the session ends, even if the source returns to its entry value. A source whose mask bit is 0 never sets it.
- R6: nxt is 0 in every cycle.
- R7: STP does not end suspend until the dwell count has reached MIN_DWELL. DIR stays high for at least MIN_DWELL+1 cycles. With STP held from the start, DIR stays high for exactly MIN_DWELL+1 cycles.
- R8: The cycle after a qualifying STP, dir is 0 and susp_en_o reads 1 again.
- R9: If an unmasked source that changed during suspend still differs from its entry value at the exit edge, the block follows the one-cycle release with two more dir-high cycles. The first is a turnaround with dout = 00h. The second is an RX CMD byte with dout[1:0] = linestate, dout[4] = 1 and all other bits 0. Then dir returns to 0.
- R10: If no such change is still present at exit, dir stays 0 after the release.
- R11: Each new entry clears the interrupt flag and restarts the dwell count, so dout[3] reads 0 at the start of the next session.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_wr | input | 1 | Write strobe for the function control register |
| fc_wdata | input | 8 | Function control write data; bit SUSP_BIT is suspend-enable |
| susp_en_o | output | 1 | Read-back of suspend-enable (1 = run, 0 = suspend) |
| stp | input | 1 | Link stop request |
| linestate | input | 2 | Line-state bits from the receivers |
| irq_src | input | N_IRQ | Interrupt source levels |
| irq_mask | input | N_IRQ | Per-source enable, 1 = unmasked |
| dir | output | 1 | Bus direction, 1 = PHY drives |
| nxt | output | 1 | Next-data strobe |
| dout | output | 8 | PHY-driven data byte |

## Verification
The bench builds the block with its defaults: N_IRQ = 4, MIN_DWELL = 120 and SUSP_BIT = 6, with mask 1011b, so one source is always masked. The full 120-cycle dwell stays within reach in every session, so the exact DIR-high length, an early STP pulse at cycle 30 and STP arriving late can all be measured. Sessions that keep an interrupt change, undo it, or change only the masked source exercise all three wake outcomes. Random sessions mix line-state and source changes.

// File: rtl/ulpi_lpm_ctrl.sv
module ulpi_lpm_ctrl #(
  parameter int N_IRQ     = 4,
  parameter int MIN_DWELL = 120,
  parameter int SUSP_BIT  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_wr,
  input  logic [7:0]       fc_wdata,
  output logic             susp_en_o,
  input  logic             stp,
  input  logic [1:0]       linestate,
  input  logic [N_IRQ-1:0] irq_src,
  input  logic [N_IRQ-1:0] irq_mask,
  output logic             dir,
  output logic             nxt,
  output logic [7:0]       dout
);
  localparam int CW = $clog2(MIN_DWELL + 1);
  localparam logic [CW-1:0] DWELL_MAX = CW'(MIN_DWELL);

  typedef enum logic [2:0] {
    ST_SYNC, ST_ENT_TA, ST_LPM, ST_EXIT_TA, ST_RX_TA, ST_RXCMD
  } state_t;

  state_t           state;
  logic [CW-1:0]    dwell;
  logic [N_IRQ-1:0] snap, chg;
  logic             pend;
  logic [N_IRQ-1:0] diff;
  logic             dwell_done;

  assign diff       = (irq_src ^ snap) & irq_mask;
  assign dwell_done = (dwell >= DWELL_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_SYNC;
      susp_en_o <= 1'b1;
      dwell     <= '0;
      snap      <= '0;
      chg       <= '0;
      pend      <= 1'b0;
    end else begin
      case (state)
        ST_SYNC: begin
          if (fc_wr && !fc_wdata[SUSP_BIT]) begin
            state     <= ST_ENT_TA;
            susp_en_o <= 1'b0;
            dwell     <= '0;
            snap      <= irq_src;
            chg       <= '0;
          end
        end
        ST_ENT_TA: begin
          state <= ST_LPM;
          chg   <= chg | diff;
          if (!dwell_done) dwell <= dwell + CW'(1);
        end
        ST_LPM: begin
          chg <= chg | diff;
          if (!dwell_done) dwell <= dwell + CW'(1);
          if (stp && dwell_done) begin
            state     <= ST_EXIT_TA;
            susp_en_o <= 1'b1;
            pend      <= |(chg & diff);
          end
        end
        ST_EXIT_TA: state <= pend ? ST_RX_TA : ST_SYNC;
        ST_RX_TA:   state <= ST_RXCMD;
        ST_RXCMD:   state <= ST_SYNC;
        default:    state <= ST_SYNC;
      endcase
    end
  end

  assign dir = (state == ST_ENT_TA) || (state == ST_LPM) ||
               (state == ST_RX_TA)  || (state == ST_RXCMD);
  assign nxt = 1'b0;

  always_comb begin
    case (state)
      ST_LPM:   dout = {4'b0000, |chg, 1'b0, linestate};
      ST_RXCMD: dout = {3'b000, 1'b1, 2'b00, linestate};
      default:  dout = 8'h00;
    endcase
  end
endmodule

// File: rtl/ulpi_lpm_ctrl_chk.sv
module ulpi_lpm_ctrl_chk #(
  parameter int MIN_DWELL = 120
) (
  input logic       clk,
  input logic       rst_n,
  input logic       susp_en_o,
  input logic       dir,
  input logic [1:0] linestate,
  input logic [7:0] dout
);
  int low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          low_cnt <= 0;
    else if (susp_en_o)  low_cnt <= 0;
    else if (low_cnt < MIN_DWELL + 4) low_cnt <= low_cnt + 1;
  end

  a_r2_entry_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(susp_en_o) |-> dir);

  a_r3_turnaround_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir) |-> (dout == 8'h00));

  a_r4_lpm_mapping: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && $past(dir) && !susp_en_o) |->
      (dout[1:0] == linestate && !dout[2] && dout[7:4] == 4'h0));

  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && !susp_en_o && $past(dir) && $past(!susp_en_o) && $past(dout[3])) |-> dout[3]);

  a_r7_min_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_en_o) |-> (low_cnt >= MIN_DWELL));

  a_r8_exit_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_en_o) |-> !dir);

  a_r9_rxcmd_format: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && $past(dir) && susp_en_o) |->
      (dout[4] && dout[7:5] == 3'b000 && dout[3:2] == 2'b00 && dout[1:0] == linestate));
endmodule

bind ulpi_lpm_ctrl ulpi_lpm_ctrl_chk #(.MIN_DWELL(MIN_DWELL)) chk_i (
  .clk(clk), .rst_n(rst_n), .susp_en_o(susp_en_o), .dir(dir),
  .linestate(linestate), .dout(dout)
);

// File: tb/ulpi_lpm_ctrl_tb_top.sv
module ulpi_lpm_ctrl_tb_top;
  localparam int N_IRQ = 4, MIN_DWELL = 120, SUSP_BIT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fc_wr = 1'b0;
  logic [7:0] fc_wdata = 8'h00;
  logic stp = 1'b0;
  logic [1:0] linestate = 2'b00;
  logic [N_IRQ-1:0] irq_src = '0;
  logic [N_IRQ-1:0] irq_mask = 4'b1011;
  logic susp_en_o, dir, nxt;
  logic [7:0] dout;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ulpi_lpm_ctrl #(.N_IRQ(N_IRQ), .MIN_DWELL(MIN_DWELL), .SUSP_BIT(SUSP_BIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .fc_wr(fc_wr), .fc_wdata(fc_wdata),
    .susp_en_o(susp_en_o), .stp(stp), .linestate(linestate),
    .irq_src(irq_src), .irq_mask(irq_mask), .dir(dir), .nxt(nxt), .dout(dout)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] lpm_byte(input logic flag, input logic [1:0] ls);
    return {4'b0000, flag, 1'b0, ls};
  endfunction

  function automatic logic [7:0] rxcmd_byte(input logic [1:0] ls);
    return {3'b000, 1'b1, 2'b00, ls};
  endfunction

  // mode 0: unmasked change kept; 1: unmasked change undone; 2: random; 3: masked only
  task automatic session(input int mode, input int stp_from);
    logic [N_IRQ-1:0] snap, sticky;
    int k;
    bit exited, pend;
    int exp_len;
    fc_wr = 1'b1;
    fc_wdata = 8'($urandom) & ~(8'h01 << SUSP_BIT);
    stp = 1'b0;
    snap = irq_src;
    sticky = '0;
    pend = 1'b0;
    step();
    fc_wr = 1'b0;
    k = 1;
    exited = 0;
    while (!exited) begin
      linestate = 2'($urandom);
      stp = (k >= stp_from) || (k == 30);
      if (mode == 0 && k == 10) irq_src[0] = ~irq_src[0];
      if (mode == 0 && k == 20) irq_src[2] = ~irq_src[2];
      if (mode == 1 && k == 10) irq_src[1] = ~irq_src[1];
      if (mode == 1 && k == 40) irq_src[1] = ~irq_src[1];
      if (mode == 3 && (k % 17) == 5) irq_src[2] = ~irq_src[2];
      if (mode == 2 && ($urandom % 12) == 0) begin
        int b = int'($urandom % N_IRQ);
        irq_src[b] = ~irq_src[b];
      end
      #2;
      check("R6 nxt low", 32'(nxt), 32'd0);
      check("R7 dir held in suspend", 32'(dir), 32'd1);
      if (k == 1) begin
        check("R2 susp_en cleared", 32'(susp_en_o), 32'd0);
        check("R3 turnaround byte", 32'(dout), 32'h00);
      end else begin
        check("R4 R5 status byte", 32'(dout), 32'(lpm_byte(|sticky, linestate)));
      end
      if (mode == 1 && k == 2) check("R11 flag cleared on entry", 32'(dout[3]), 32'd0);
      if (k >= 2 && stp && (k - 1) >= MIN_DWELL) begin
        exited = 1;
        pend = |(sticky & ((irq_src ^ snap) & irq_mask));
      end
      sticky = sticky | ((irq_src ^ snap) & irq_mask);
      step();
      k++;
    end
    stp = 1'b0;
    #2;
    exp_len = (stp_from > MIN_DWELL + 1) ? stp_from : MIN_DWELL + 1;
    check("R7 dir high length", 32'(k - 1), 32'(exp_len));
    check("R8 dir released", 32'(dir), 32'd0);
    check("R8 susp_en restored", 32'(susp_en_o), 32'd1);
    if (mode == 0) check("R9 model pending", 32'(pend), 32'd1);
    if (mode == 1 || mode == 3) check("R10 model not pending", 32'(pend), 32'd0);
    step();
    linestate = 2'($urandom);
    #2;
    if (pend) begin
      check("R9 rx turnaround dir", 32'(dir), 32'd1);
      check("R9 rx turnaround byte", 32'(dout), 32'h00);
      step();
      linestate = 2'($urandom);
      #2;
      check("R9 rxcmd dir", 32'(dir), 32'd1);
      check("R9 rxcmd byte", 32'(dout), 32'(rxcmd_byte(linestate)));
      step();
      #2;
      check("R9 bus returned", 32'(dir), 32'd0);
    end else begin
      for (int i = 0; i < 3; i++) begin
        check("R10 no rxcmd", 32'(dir), 32'd0);
        step();
        #2;
      end
    end
    step();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    irq_src = 4'($urandom);
    repeat (3) @(negedge clk);
    #2;
    check("R1 dir in reset", 32'(dir), 32'd0);
    check("R1 susp_en in reset", 32'(susp_en_o), 32'd1);
    rst_n = 1'b1;
    step();
    #2;
    check("R1 dir after reset", 32'(dir), 32'd0);
    check("R1 nxt after reset", 32'(nxt), 32'd0);
    check("R1 dout after reset", 32'(dout), 32'h00);
    check("R1 susp_en after reset", 32'(susp_en_o), 32'd1);
    fc_wr = 1'b1;
    fc_wdata = 8'hFF;
    step();
    fc_wr = 1'b0;
    #2;
    check("R2 write with bit set ignored dir", 32'(dir), 32'd0);
    check("R2 write with bit set ignored susp", 32'(susp_en_o), 32'd1);
    step();
    session(0, 2);
    session(1, 2);
    session(3, 150);
    for (int s = 0; s < 4; s++)
      session(2, MIN_DWELL - 20 + int'($urandom % 60));
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule